// File: doc/BRIEF.md
# Configurable Double-Data-Rate Pad Cell

This block sits between a package pad and core logic and carries three independent paths: data launched toward the pad, data captured from the pad, and an enable that decides whether the output driver is active or high impedance. Each path can bypass storage, or pass through a pair of storage elements that act either as edge-triggered flops or as level-sensitive latches. One element of each pair works on the high phase of the cell clock and the other on the low phase, so the cell can capture and launch two bits per clock period.

Every signal that enters the cell, clock, reset and enables included, has its own static inversion bit. The path modes, the capture delay on the input side and the reset values of the pairs are static configuration inputs as well. The pad is modelled as three plain ports (`pad_in`, `pad_out`, `pad_oe`). A build parameter yields a receive-only cell whose driver is never enabled.

Top module: `ddrio_cell`

## Requirements
- R1: With `cfg_out_mode` at 2'b00 or 2'b11 (direct), `pad_out` follows `out_d_hi` in both clock phases and `out_d_lo` has no effect; with `cfg_hiz_mode` direct, `pad_oe` is the inverse of `hiz_hi` (hiz high means driver off).
- R2: `cfg_inv` inverts one entering signal per bit: 0 clk, 1 rst, 2 in_ce, 3 out_ce, 4 hiz_ce, 5 out_d_hi, 6 out_d_lo, 7 hiz_hi, 8 hiz_lo, 9 pad_in. An inverted clock moves the high-phase element to the falling edge of `clk`.
- R3: With a path mode of 2'b01 (flop), the high-phase element loads on the rising edge, the low-phase element on the falling edge, and the pad sees the high-phase element while the clock is high and the low-phase element while it is low.
- R4: The input pair loads the pad value into `in_cap_hi` on the rising edge and into `in_cap_lo` on the falling edge when `cfg_in_latch` is 0.
- R5: With latch mode (2'b10 on the output side, `cfg_in_latch` 1 on the input side), the high-phase element is transparent while the clock is high and holds while it is low; the low-phase element does the opposite.
- R6: Each pair has its own clock enable (`in_ce`, `out_ce`, `hiz_ce`); while it is inactive both elements of that pair hold.
- R7: Reset is asynchronous and active high: it loads the input pair with `cfg_in_init`, the output pair with `cfg_out_init`, and the enable pair with the driver-off state, so `pad_oe` is 0 in a registered enable mode.
- R8: With `cfg_in_dly` 0, `in_live` follows `pad_in` at once; with 1, `in_live` and the input pair see `pad_in` delayed by `IN_DLY` rising clock edges.
- R9: While the driver is off (`pad_oe` 0), the input path still captures the pad normally.
- R10: With `INPUT_ONLY` set, `pad_oe` and `pad_out` stay 0 for every input, and the input path works as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst | input | 1 | Asynchronous reset, active high before inversion |
| in_ce | input | 1 | Clock enable of the input pair |
| out_ce | input | 1 | Clock enable of the output pair |
| hiz_ce | input | 1 | Clock enable of the driver-enable pair |
| out_d_hi | input | 1 | Output bit for the high phase (also the direct bit) |
| out_d_lo | input | 1 | Output bit for the low phase |
| hiz_hi | input | 1 | High-impedance request for the high phase (direct bit) |
| hiz_lo | input | 1 | High-impedance request for the low phase |
| pad_in | input | 1 | Value seen on the pad |
| cfg_inv | input | 10 | Per-signal inversion bits |
| cfg_in_latch | input | 1 | Input pair as latches when 1 |
| cfg_in_dly | input | 1 | Insert the input delay line when 1 |
| cfg_in_init | input | 1 | Reset value of the input pair |
| cfg_out_mode | input | 2 | Output path mode: 00/11 direct, 01 flop, 10 latch |
| cfg_out_init | input | 1 | Reset value of the output pair |
| cfg_hiz_mode | input | 2 | Driver-enable path mode, same encoding |
| in_live | output | 1 | Unregistered input value |
| in_cap_hi | output | 1 | Input value stored in the high-phase element |
| in_cap_lo | output | 1 | Input value stored in the low-phase element |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Driver enable |

## Verification
The bench probes the phase boundaries: a flop-mode output whose data changes mid-phase must not move the pad, while the same change in latch mode must pass straight through, so a design that swapped the element kinds or the phase select shows the wrong bit in half of each period. Clock-enable and enable-inversion steps catch a pair that loads when it should hold, and the inverted-clock step catches an element still tied to the rising edge. The delay step counts edges to expose a line of the wrong length or a capture that skips it, and the reset and disabled-driver steps catch a cell that drives the pad after reset or stops capturing while the driver is off.

// File: rtl/ddrio_pkg.sv
package ddrio_pkg;
   localparam int INV_W   = 10;
   localparam int INV_CLK = 0;
   localparam int INV_RST = 1;
   localparam int INV_ICE = 2;
   localparam int INV_OCE = 3;
   localparam int INV_TCE = 4;
   localparam int INV_OHI = 5;
   localparam int INV_OLO = 6;
   localparam int INV_THI = 7;
   localparam int INV_TLO = 8;
   localparam int INV_PAD = 9;

   typedef enum logic [1:0] {
      MODE_DIRECT  = 2'b00,
      MODE_FLOP    = 2'b01,
      MODE_LATCH   = 2'b10,
      MODE_DIRECT2 = 2'b11
   } path_mode_e;

   function automatic logic mode_stored(input logic [1:0] m);
      return (m == MODE_FLOP) || (m == MODE_LATCH);
   endfunction
endpackage

// File: rtl/ddrio_store_pair.sv
module ddrio_store_pair #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ce,
   input  logic         latch_mode,
   input  logic [W-1:0] init,
   input  logic [W-1:0] d_hi,
   input  logic [W-1:0] d_lo,
   output logic [W-1:0] q_hi,
   output logic [W-1:0] q_lo
);
   if (W < 1) begin : g_bad_width
      $error("ddrio_store_pair: W must be at least 1");
   end

   logic [W-1:0] f_hi, f_lo, l_hi, l_lo;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)     f_hi <= init;
      else if (ce) f_hi <= d_hi;
   end

   always_ff @(negedge clk or posedge rst) begin
      if (rst)     f_lo <= init;
      else if (ce) f_lo <= d_lo;
   end

   always_latch begin
      if (rst)             l_hi <= init;
      else if (clk && ce)  l_hi <= d_hi;
   end

   always_latch begin
      if (rst)             l_lo <= init;
      else if (!clk && ce) l_lo <= d_lo;
   end

   assign q_hi = latch_mode ? l_hi : f_hi;
   assign q_lo = latch_mode ? l_lo : f_lo;
endmodule

// File: rtl/ddrio_delay.sv
module ddrio_delay #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic use_dly,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("ddrio_delay: STAGES must be at least 1");
   end

   logic [STAGES-1:0] line;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or posedge rst) begin
         if (rst) line <= '0;
         else     line <= d;
      end
   end else begin : g_many
      always_ff @(posedge clk or posedge rst) begin
         if (rst) line <= '0;
         else     line <= {line[STAGES-2:0], d};
      end
   end

   assign q = use_dly ? line[STAGES-1] : d;
endmodule

// File: rtl/ddrio_phase_mux.sv
module ddrio_phase_mux
   import ddrio_pkg::*;
(
   input  logic       clk,
   input  logic [1:0] mode,
   input  logic       direct,
   input  logic       q_hi,
   input  logic       q_lo,
   output logic       y
);
   always_comb begin
      if (mode_stored(mode)) y = clk ? q_hi : q_lo;
      else                   y = direct;
   end
endmodule

// File: rtl/ddrio_cell.sv
module ddrio_cell
   import ddrio_pkg::*;
#(
   parameter bit INPUT_ONLY = 1'b0,
   parameter int IN_DLY     = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_ce,
   input  logic             out_ce,
   input  logic             hiz_ce,
   input  logic             out_d_hi,
   input  logic             out_d_lo,
   input  logic             hiz_hi,
   input  logic             hiz_lo,
   input  logic             pad_in,
   input  logic [INV_W-1:0] cfg_inv,
   input  logic             cfg_in_latch,
   input  logic             cfg_in_dly,
   input  logic             cfg_in_init,
   input  logic [1:0]       cfg_out_mode,
   input  logic             cfg_out_init,
   input  logic [1:0]       cfg_hiz_mode,
   output logic             in_live,
   output logic             in_cap_hi,
   output logic             in_cap_lo,
   output logic             pad_out,
   output logic             pad_oe
);
   if (IN_DLY < 1) begin : g_bad_dly
      $error("ddrio_cell: IN_DLY must be at least 1");
   end

   logic clk_e, rst_e, pad_e, pad_d;
   assign clk_e = clk    ^ cfg_inv[INV_CLK];
   assign rst_e = rst    ^ cfg_inv[INV_RST];
   assign pad_e = pad_in ^ cfg_inv[INV_PAD];

   ddrio_delay #(.STAGES(IN_DLY)) u_in_dly (
      .clk(clk_e), .rst(rst_e), .use_dly(cfg_in_dly), .d(pad_e), .q(pad_d)
   );

   assign in_live = pad_d;

   ddrio_store_pair #(.W(1)) u_in_pair (
      .clk(clk_e), .rst(rst_e), .ce(in_ce ^ cfg_inv[INV_ICE]),
      .latch_mode(cfg_in_latch), .init(cfg_in_init),
      .d_hi(pad_d), .d_lo(pad_d), .q_hi(in_cap_hi), .q_lo(in_cap_lo)
   );

   if (INPUT_ONLY) begin : g_rx_only
      assign pad_out = 1'b0;
      assign pad_oe  = 1'b0;
   end else begin : g_full
      logic o_hi, o_lo, oq_hi, oq_lo;
      logic t_hi, t_lo, tq_hi, tq_lo, hiz_sel;

      assign o_hi = out_d_hi ^ cfg_inv[INV_OHI];
      assign o_lo = out_d_lo ^ cfg_inv[INV_OLO];
      assign t_hi = hiz_hi   ^ cfg_inv[INV_THI];
      assign t_lo = hiz_lo   ^ cfg_inv[INV_TLO];

      ddrio_store_pair #(.W(1)) u_out_pair (
         .clk(clk_e), .rst(rst_e), .ce(out_ce ^ cfg_inv[INV_OCE]),
         .latch_mode(cfg_out_mode == MODE_LATCH), .init(cfg_out_init),
         .d_hi(o_hi), .d_lo(o_lo), .q_hi(oq_hi), .q_lo(oq_lo)
      );

      ddrio_store_pair #(.W(1)) u_hiz_pair (
         .clk(clk_e), .rst(rst_e), .ce(hiz_ce ^ cfg_inv[INV_TCE]),
         .latch_mode(cfg_hiz_mode == MODE_LATCH), .init(1'b1),
         .d_hi(t_hi), .d_lo(t_lo), .q_hi(tq_hi), .q_lo(tq_lo)
      );

      ddrio_phase_mux u_out_mux (
         .clk(clk_e), .mode(cfg_out_mode), .direct(o_hi),
         .q_hi(oq_hi), .q_lo(oq_lo), .y(pad_out)
      );

      ddrio_phase_mux u_hiz_mux (
         .clk(clk_e), .mode(cfg_hiz_mode), .direct(t_hi),
         .q_hi(tq_hi), .q_lo(tq_lo), .y(hiz_sel)
      );

      assign pad_oe = ~hiz_sel;
   end
endmodule

// File: rtl/ddrio_cell_chk.sv
module ddrio_cell_chk
   import ddrio_pkg::*;
#(
   parameter bit INPUT_ONLY = 1'b0
) (
   input logic             clk,
   input logic             rst,
   input logic             in_ce,
   input logic             out_d_hi,
   input logic             hiz_hi,
   input logic             pad_in,
   input logic [INV_W-1:0] cfg_inv,
   input logic             cfg_in_latch,
   input logic             cfg_in_dly,
   input logic [1:0]       cfg_out_mode,
   input logic [1:0]       cfg_hiz_mode,
   input logic             in_live,
   input logic             in_cap_hi,
   input logic             pad_out,
   input logic             pad_oe
);
   logic rst_e;
   assign rst_e = rst ^ cfg_inv[INV_RST];

   // R7: reset holds the driver off in a registered enable mode
   assert_reset_hiz_R7: assert property (@(posedge clk)
      (rst_e && mode_stored(cfg_hiz_mode)) |-> !pad_oe);

   // R10: a receive-only build never drives
   assert_rx_only_quiet_R10: assert property (@(posedge clk) disable iff (rst_e)
      INPUT_ONLY |-> (!pad_oe && !pad_out));

   // R1: direct output mode passes the high-phase bit
   assert_direct_out_R1: assert property (@(negedge clk) disable iff (rst_e)
      (!INPUT_ONLY && !mode_stored(cfg_out_mode)) |-> (pad_out == (out_d_hi ^ cfg_inv[INV_OHI])));

   // R1: direct enable mode drives unless high impedance is requested
   assert_direct_oe_R1: assert property (@(negedge clk) disable iff (rst_e)
      (!INPUT_ONLY && !mode_stored(cfg_hiz_mode)) |-> (pad_oe == !(hiz_hi ^ cfg_inv[INV_THI])));

   // R8: bypassed delay makes the live input follow the pad
   assert_bypass_live_R8: assert property (@(posedge clk) disable iff (rst_e)
      !cfg_in_dly |-> (in_live == (pad_in ^ cfg_inv[INV_PAD])));

   // R4: the rising edge stores the pad value in the high-phase element
   assert_flop_capture_R4: assert property (@(posedge clk) disable iff (rst_e)
      (!cfg_in_latch && !cfg_inv[INV_CLK] && !cfg_in_dly && (in_ce ^ cfg_inv[INV_ICE]))
      |=> (cfg_in_latch || cfg_inv[INV_CLK] ||
           in_cap_hi == $past(pad_in ^ cfg_inv[INV_PAD])));
endmodule

bind ddrio_cell ddrio_cell_chk #(.INPUT_ONLY(INPUT_ONLY)) u_ddrio_chk (
   .clk(clk), .rst(rst), .in_ce(in_ce), .out_d_hi(out_d_hi), .hiz_hi(hiz_hi),
   .pad_in(pad_in), .cfg_inv(cfg_inv), .cfg_in_latch(cfg_in_latch),
   .cfg_in_dly(cfg_in_dly), .cfg_out_mode(cfg_out_mode), .cfg_hiz_mode(cfg_hiz_mode),
   .in_live(in_live), .in_cap_hi(in_cap_hi), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/test_ddrio_cell.sv
`timescale 1ns/1ps
module test_ddrio_cell;
   logic       clk = 1'b0;
   logic       rst = 1'b0;
   logic       in_ce = 1'b1, out_ce = 1'b1, hiz_ce = 1'b1;
   logic       out_d_hi = 1'b0, out_d_lo = 1'b0, hiz_hi = 1'b0, hiz_lo = 1'b0;
   logic       pad_in = 1'b0;
   logic [9:0] cfg_inv = '0;
   logic       cfg_in_latch = 1'b0, cfg_in_dly = 1'b0, cfg_in_init = 1'b1;
   logic [1:0] cfg_out_mode = 2'b01;
   logic       cfg_out_init = 1'b1;
   logic [1:0] cfg_hiz_mode = 2'b01;
   logic       in_live, in_cap_hi, in_cap_lo, pad_out, pad_oe;
   logic       rx_live, rx_cap_hi, rx_cap_lo, rx_pad_out, rx_pad_oe;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   ddrio_cell #(.INPUT_ONLY(1'b0), .IN_DLY(2)) i_ddrio_cell (
      .clk(clk), .rst(rst), .in_ce(in_ce), .out_ce(out_ce), .hiz_ce(hiz_ce),
      .out_d_hi(out_d_hi), .out_d_lo(out_d_lo), .hiz_hi(hiz_hi), .hiz_lo(hiz_lo),
      .pad_in(pad_in), .cfg_inv(cfg_inv), .cfg_in_latch(cfg_in_latch),
      .cfg_in_dly(cfg_in_dly), .cfg_in_init(cfg_in_init), .cfg_out_mode(cfg_out_mode),
      .cfg_out_init(cfg_out_init), .cfg_hiz_mode(cfg_hiz_mode),
      .in_live(in_live), .in_cap_hi(in_cap_hi), .in_cap_lo(in_cap_lo),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   ddrio_cell #(.INPUT_ONLY(1'b1), .IN_DLY(2)) i_ddrio_cell_rx (
      .clk(clk), .rst(rst), .in_ce(in_ce), .out_ce(out_ce), .hiz_ce(hiz_ce),
      .out_d_hi(out_d_hi), .out_d_lo(out_d_lo), .hiz_hi(hiz_hi), .hiz_lo(hiz_lo),
      .pad_in(pad_in), .cfg_inv(cfg_inv), .cfg_in_latch(cfg_in_latch),
      .cfg_in_dly(cfg_in_dly), .cfg_in_init(cfg_in_init), .cfg_out_mode(cfg_out_mode),
      .cfg_out_init(cfg_out_init), .cfg_hiz_mode(cfg_hiz_mode),
      .in_live(rx_live), .in_cap_hi(rx_cap_hi), .in_cap_lo(rx_cap_lo),
      .pad_out(rx_pad_out), .pad_oe(rx_pad_oe)
   );

   // bits [10:9] mode, [8] inv out_d_hi, [7] inv hiz_hi, [6] inv pad_in,
   // [5] out_d_hi, [4] hiz_hi, [3] pad_in, [2] exp pad_out, [1] exp pad_oe, [0] exp in_live
   localparam logic [10:0] VECS [8] = '{
      11'b00_000_101_111,
      11'b00_000_000_010,
      11'b00_100_000_110,
      11'b00_010_101_101,
      11'b00_001_111_100,
      11'b11_000_100_110,
      11'b11_111_110_011,
      11'b00_101_111_000
   };

   task automatic hi(input int off);
      @(posedge clk); #(off);
   endtask

   task automatic lo(input int off);
      @(negedge clk); #(off);
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #4_000_000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      #1 rst = 1'b1;
      // R7: reset state
      hi(7);
      chk("R7", "pad_oe in reset", pad_oe, 1'b0);
      chk("R7", "in_cap_hi init", in_cap_hi, 1'b1);
      chk("R7", "in_cap_lo init", in_cap_lo, 1'b1);
      chk("R7", "pad_out init high phase", pad_out, 1'b1);
      lo(7);
      chk("R7", "pad_out init low phase", pad_out, 1'b1);

      // R3: flop DDR launch
      rst = 1'b0; out_d_hi = 1'b0; out_d_lo = 1'b1; hiz_hi = 1'b0; hiz_lo = 1'b0; pad_in = 1'b0;
      hi(7);
      chk("R3", "pad_out high phase", pad_out, 1'b0);
      chk("R3", "pad_oe after launch", pad_oe, 1'b1);
      lo(7);
      chk("R3", "pad_out low phase", pad_out, 1'b1);
      chk("R3", "pad_oe low phase", pad_oe, 1'b1);
      out_d_hi = 1'b1; out_d_lo = 1'b0;
      hi(7);
      chk("R3", "pad_out next high", pad_out, 1'b1);
      #1 out_d_hi = 1'b0;
      #1 chk("R3", "flop holds mid phase", pad_out, 1'b1);
      lo(7);
      chk("R3", "pad_out next low", pad_out, 1'b0);

      // R4: input flop capture on both edges
      pad_in = 1'b1;
      hi(3); pad_in = 1'b0;
      lo(7);
      chk("R4", "in_cap_hi rising capture", in_cap_hi, 1'b1);
      chk("R4", "in_cap_lo falling capture", in_cap_lo, 1'b0);

      // R6: clock enables off hold the pairs
      out_ce = 1'b0; in_ce = 1'b0; out_d_hi = 1'b1; out_d_lo = 1'b1; pad_in = 1'b0;
      hi(3); pad_in = 1'b1;
      #4 chk("R6", "pad_out held high phase", pad_out, 1'b0);
      lo(7);
      chk("R6", "in_cap_hi held", in_cap_hi, 1'b1);
      chk("R6", "in_cap_lo held", in_cap_lo, 1'b0);
      chk("R6", "pad_out held low phase", pad_out, 1'b0);

      // R2: inverted enables make low inputs active
      cfg_inv[2] = 1'b1; cfg_inv[3] = 1'b1; pad_in = 1'b0;
      hi(7);
      chk("R2", "inverted in_ce loads", in_cap_hi, 1'b0);
      chk("R2", "inverted out_ce loads", pad_out, 1'b1);
      lo(7);
      chk("R2", "inverted out_ce low phase", pad_out, 1'b1);
      cfg_inv = '0; in_ce = 1'b1; out_ce = 1'b1;

      // R5: latch mode transparency and hold
      cfg_in_latch = 1'b1; cfg_out_mode = 2'b10;
      hi(3); pad_in = 1'b1; out_d_hi = 1'b0;
      #4 chk("R5", "in latch transparent high", in_cap_hi, 1'b1);
      chk("R5", "out latch follows high", pad_out, 1'b0);
      #1 out_d_hi = 1'b1;
      #1 chk("R5", "out latch follows change", pad_out, 1'b1);
      lo(3); pad_in = 1'b0;
      #4 chk("R5", "in latch holds low", in_cap_hi, 1'b1);
      chk("R5", "in low latch transparent", in_cap_lo, 1'b0);
      chk("R5", "pad_out low latch", pad_out, 1'b1);
      #1 out_d_lo = 1'b0;
      #1 chk("R5", "low latch follows change", pad_out, 1'b0);
      cfg_in_latch = 1'b0; cfg_out_mode = 2'b01;

      // R2: inverted clock moves the high element to the falling edge
      lo(3); pad_in = 1'b0; cfg_inv[0] = 1'b1;
      hi(3); pad_in = 1'b1;
      lo(7);
      chk("R2", "inverted clk falling capture", in_cap_hi, 1'b1);
      hi(7);
      chk("R2", "inverted clk rising capture", in_cap_lo, 1'b1);
      lo(3); cfg_inv[0] = 1'b0; pad_in = 1'b0;

      // R8: input delay line
      hi(3);
      hi(3); cfg_in_dly = 1'b1; pad_in = 1'b1;
      #4 chk("R8", "delayed live before edges", in_live, 1'b0);
      hi(7);
      chk("R8", "delayed live after one edge", in_live, 1'b0);
      hi(7);
      chk("R8", "delayed live after two edges", in_live, 1'b1);
      chk("R8", "capture uses delayed value", in_cap_hi, 1'b0);
      lo(3); cfg_in_dly = 1'b0;

      // R9: driver off, capture still works
      cfg_hiz_mode = 2'b00; hiz_hi = 1'b1; pad_in = 1'b0;
      #2 chk("R9", "pad_oe off", pad_oe, 1'b0);
      hi(3); pad_in = 1'b1;
      lo(7);
      chk("R9", "pad_oe stays off", pad_oe, 1'b0);
      hi(3); pad_in = 1'b0;
      lo(7);
      chk("R9", "capture hi while off", in_cap_hi, 1'b1);
      chk("R9", "capture lo while off", in_cap_lo, 1'b0);

      // R1, R2, R10: direct path vector table
      for (int k = 0; k < 8; k++) begin
         logic [10:0] v;
         string req;
         v = VECS[k];
         req = (v[8] | v[7] | v[6]) ? "R2" : "R1";
         lo(3);
         cfg_out_mode = v[10:9]; cfg_hiz_mode = v[10:9];
         cfg_inv = {v[6], 1'b0, v[7], 1'b0, v[8], 5'b0};
         out_d_hi = v[5]; out_d_lo = ~v[5]; hiz_hi = v[4]; hiz_lo = ~v[4]; pad_in = v[3];
         #2;
         chk(req, "direct pad_out", pad_out, v[2]);
         chk(req, "direct pad_oe", pad_oe, v[1]);
         chk(req, "direct in_live", in_live, v[0]);
         chk("R10", "rx-only pad_oe", rx_pad_oe, 1'b0);
         chk("R10", "rx-only pad_out", rx_pad_out, 1'b0);
         chk("R10", "rx-only in_live", rx_live, v[0]);
         hi(5);
         chk("R1", "direct ignores low bit", pad_out, v[2]);
      end

      // R7: reset in mid-run with new init values
      lo(3);
      cfg_inv = '0; cfg_out_mode = 2'b01; cfg_hiz_mode = 2'b01;
      hiz_hi = 1'b0; hiz_lo = 1'b0; out_d_hi = 1'b1; out_d_lo = 1'b1; pad_in = 1'b1;
      cfg_out_init = 1'b0; cfg_in_init = 1'b0;
      hi(7);
      chk("R3", "driving before reset", pad_oe, 1'b1);
      chk("R3", "pad_out before reset", pad_out, 1'b1);
      lo(3); rst = 1'b1;
      #2;
      chk("R7", "reset turns driver off", pad_oe, 1'b0);
      chk("R7", "reset loads out init", pad_out, 1'b0);
      chk("R7", "reset loads in init lo", in_cap_lo, 1'b0);
      hi(7);
      chk("R7", "reset loads in init hi", in_cap_hi, 1'b0);
      chk("R7", "reset holds out init", pad_out, 1'b0);
      chk("R7", "reset holds driver off", pad_oe, 1'b0);
      lo(3); rst = 1'b0;
      hi(7);
      finish_run();
   end
endmodule